// File: doc/BRIEF.md
# Dual-Phase Serial Frame Transmitter

This block turns a stream of parallel words into a serial data line, one frame at a time. A frame begins when a frame sync strobe is seen on a launch edge of the bit clock. After a programmable lead-in of zero to three bit clocks, the block shifts out the elements of the first phase. If the second phase is enabled, the elements of the second phase follow. Each phase has its own element count and element width, set by encoded configuration inputs. The configuration must stay stable while a frame is in progress.

The bit clock is an input that is generated in the system clock domain and sampled on every system clock. The launch edge, rising or falling, is selectable. Words arrive on a valid/ready handshake, and one word is taken at the start of each element. A missing word is replaced by zeros and reported as an underrun. A frame sync that arrives during a frame does not restart the frame and is reported as a sync error.

Top module: `dual_phase_ser_tx`

## Requirements
- R1: The element width code maps as 0→8, 1→10, 2→12, 3→14, 4→16, 5→20, 6→24 and 7→32 bits.
- R2: The element count inputs hold the number of elements minus one, so 0 sends one element and 11 sends twelve.
- R3: When `ph2_en_i` is 1, the phase-2 elements (count `ph2_cnt_i`, width `ph2_wcode_i`) follow the phase-1 elements in the same frame. When `ph2_en_i` is 0, the phase-2 inputs have no effect.
- R4: The first data bit is launched `dly_i` (0 to 3) launch edges after the launch edge on which frame sync was seen. Before that bit, `sdata_o` is 0.
- R5: `launch_fall_i`=0 makes rising bit-clock edges the launch edges, and `launch_fall_i`=1 makes falling edges the launch edges. `sdata_o` changes only on the system clock edge that detects a launch edge.
- R6: Each element is sent MSB first, starting from bit (width-1) of the word. Word bits above the element width are dropped.
- R7: If no word is valid when an element starts, that element is sent as zeros and `underrun_o` pulses for one system clock. The frame then continues with its remaining elements.
- R8: A frame sync seen on a launch edge while a frame is in progress is ignored and `fs_err_o` pulses for one system clock.
- R9: `busy_o` rises on the launch edge that accepts frame sync and falls on the launch edge after the last bit of the last element. Whenever `busy_o` is 0, `sdata_o` is 0.
- R10: After reset `sdata_o`, `busy_o`, `in_ready_o`, `underrun_o` and `fs_err_o` are 0.
- R11: `in_ready_o` is high only on a launch-edge cycle in which an element starts and `in_valid_i` is high. Exactly one word is taken per element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_i | input | 1 | Bit clock level, generated in the clk domain |
| fsync_i | input | 1 | Frame sync strobe, sampled on launch edges |
| launch_fall_i | input | 1 | 0: launch on rising edge, 1: launch on falling edge |
| ph2_en_i | input | 1 | Enables the second phase |
| ph1_cnt_i | input | CNT_W | Phase-1 element count minus one |
| ph1_wcode_i | input | 3 | Phase-1 element width code |
| ph2_cnt_i | input | CNT_W | Phase-2 element count minus one |
| ph2_wcode_i | input | 3 | Phase-2 element width code |
| dly_i | input | DLY_W | Bit clocks between frame sync and first data bit |
| in_data_i | input | WORD_W | Parallel word |
| in_valid_i | input | 1 | Word available |
| in_ready_o | output | 1 | Word taken this cycle |
| sdata_o | output | 1 | Serial data |
| busy_o | output | 1 | Frame in progress |
| underrun_o | output | 1 | One-cycle pulse: element started with no word |
| fs_err_o | output | 1 | One-cycle pulse: frame sync during a frame |

## Verification
The hardest case to reach from the ports is the phase handover inside a long dual-phase frame. There, the last bit of a phase-1 element must be followed at once by the MSB of a phase-2 element of a different width, and that change must happen after the lead-in delay has been counted. The stimulus drives the bit clock one edge at a time from a table of configurations, including a 16-bit element followed by twelve 20-bit elements. Every launched bit is compared against a stream built in the bench from the width table. Two directed runs starve the word source partway through a frame and strobe frame sync mid-frame, which checks that the frame keeps its length in both cases.

// File: rtl/dpt_pkg.sv
package dpt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_DATA  = 2'd2
    } tx_st_e;

    // Element width in bits for a 3-bit width code.
    function automatic int unsigned elem_bits(input logic [2:0] code);
        case (code)
            3'd0:    elem_bits = 8;
            3'd1:    elem_bits = 10;
            3'd2:    elem_bits = 12;
            3'd3:    elem_bits = 14;
            3'd4:    elem_bits = 16;
            3'd5:    elem_bits = 20;
            3'd6:    elem_bits = 24;
            default: elem_bits = 32;
        endcase
    endfunction

endpackage

// File: rtl/dpt_edge_det.sv
module dpt_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    input  logic launch_fall_i,
    output logic tick_o
);
    logic bclk_d, bclk_q;

    always_comb begin
        bclk_d = bclk_i;
        tick_o = launch_fall_i ? (bclk_q & ~bclk_i) : (~bclk_q & bclk_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bclk_q <= 1'b0;
        else        bclk_q <= bclk_d;
    end

    // A launch tick needs a level change since the previous sample (R5)
    assert_tick_on_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> (bclk_i != bclk_q));

endmodule

// File: rtl/dpt_align.sv
module dpt_align #(
    parameter int unsigned WORD_W = 32,
    localparam int unsigned BW    = $clog2(WORD_W)
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic              have_i,
    input  logic [2:0]        wcode_i,
    output logic [WORD_W-1:0] aligned_o,
    output logic [BW-1:0]     last_idx_o
);
    import dpt_pkg::*;

    int unsigned nbits;

    always_comb begin
        nbits      = elem_bits(wcode_i);
        last_idx_o = BW'(nbits - 1);
        // Element MSB goes to the top of the shifter; upper word bits fall off.
        aligned_o  = have_i ? (word_i << (WORD_W - nbits)) : '0;
    end

endmodule

// File: rtl/dual_phase_ser_tx.sv
module dual_phase_ser_tx #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned CNT_W  = 6,
    parameter int unsigned DLY_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_i,
    input  logic              fsync_i,
    input  logic              launch_fall_i,
    input  logic              ph2_en_i,
    input  logic [CNT_W-1:0]  ph1_cnt_i,
    input  logic [2:0]        ph1_wcode_i,
    input  logic [CNT_W-1:0]  ph2_cnt_i,
    input  logic [2:0]        ph2_wcode_i,
    input  logic [DLY_W-1:0]  dly_i,
    input  logic [WORD_W-1:0] in_data_i,
    input  logic              in_valid_i,
    output logic              in_ready_o,
    output logic              sdata_o,
    output logic              busy_o,
    output logic              underrun_o,
    output logic              fs_err_o
);
    import dpt_pkg::*;

    localparam int unsigned BW = $clog2(WORD_W);

    typedef struct packed {
        tx_st_e             st;
        logic [DLY_W-1:0]   dly_cnt;
        logic [BW-1:0]      bits_left;
        logic [CNT_W-1:0]   elems_left;
        logic               phase2;
        logic [WORD_W-1:0]  shreg;
        logic               sdata;
        logic               busy;
        logic               underrun;
        logic               fs_err;
    } tx_state_t;

    tx_state_t q, d;

    logic              tick;
    logic              load, load_p2, start, fin;
    logic [2:0]        ld_wcode;
    logic [WORD_W-1:0] aligned;
    logic [BW-1:0]     last_idx;

    dpt_edge_det u_edge (
        .clk           (clk),
        .rst_n         (rst_n),
        .bclk_i        (bclk_i),
        .launch_fall_i (launch_fall_i),
        .tick_o        (tick)
    );

    assign ld_wcode = load_p2 ? ph2_wcode_i : ph1_wcode_i;

    dpt_align #(.WORD_W(WORD_W)) u_align (
        .word_i     (in_data_i),
        .have_i     (in_valid_i),
        .wcode_i    (ld_wcode),
        .aligned_o  (aligned),
        .last_idx_o (last_idx)
    );

    always_comb begin
        d          = q;
        d.underrun = 1'b0;
        d.fs_err   = 1'b0;
        load       = 1'b0;
        load_p2    = 1'b0;
        start      = 1'b0;
        fin        = 1'b0;
        in_ready_o = 1'b0;

        if (tick) begin
            case (q.st)
                ST_IDLE: begin
                    start = fsync_i;
                end
                ST_DELAY: begin
                    if (q.dly_cnt == '0) begin
                        load = 1'b1;
                    end else begin
                        d.dly_cnt = q.dly_cnt - 1'b1;
                    end
                end
                ST_DATA: begin
                    if (q.bits_left != '0) begin
                        d.shreg     = q.shreg << 1;
                        d.sdata     = q.shreg[WORD_W-2];
                        d.bits_left = q.bits_left - 1'b1;
                    end else if (q.elems_left != '0) begin
                        load         = 1'b1;
                        load_p2      = q.phase2;
                        d.elems_left = q.elems_left - 1'b1;
                    end else if (!q.phase2 && ph2_en_i) begin
                        load         = 1'b1;
                        load_p2      = 1'b1;
                        d.phase2     = 1'b1;
                        d.elems_left = ph2_cnt_i;
                    end else begin
                        fin   = 1'b1;
                        start = fsync_i;
                    end
                end
                default: begin
                    d.st = ST_IDLE;
                end
            endcase

            if (fsync_i && q.busy && !fin) begin
                d.fs_err = 1'b1;
            end

            if (fin && !start) begin
                d.st    = ST_IDLE;
                d.busy  = 1'b0;
                d.sdata = 1'b0;
            end

            if (start) begin
                d.busy       = 1'b1;
                d.phase2     = 1'b0;
                d.elems_left = ph1_cnt_i;
                if (dly_i == '0) begin
                    load = 1'b1;
                end else begin
                    d.st      = ST_DELAY;
                    d.dly_cnt = dly_i - 1'b1;
                    d.sdata   = 1'b0;
                end
            end
        end

        if (load) begin
            d.st        = ST_DATA;
            in_ready_o  = in_valid_i;
            d.underrun  = !in_valid_i;
            d.shreg     = aligned;
            d.sdata     = aligned[WORD_W-1];
            d.bits_left = last_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign sdata_o    = q.sdata;
    assign busy_o     = q.busy;
    assign underrun_o = q.underrun;
    assign fs_err_o   = q.fs_err;

    // Words are only taken on a launch edge and only when offered (R11)
    assert_ready_on_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready_o |-> (tick && in_valid_i));

    // An underrun pulse follows an element start with no word offered (R7)
    assert_underrun_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_o |-> $past(!in_valid_i && tick));

    // Sync error only while a frame was already running (R8)
    assert_fserr_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fs_err_o |-> $past(busy_o && fsync_i));

    // Line is quiet outside a frame (R9)
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !sdata_o);

    // Serial output moves only on launch-edge cycles (R5)
    assert_data_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) |-> $stable(sdata_o));

    // Busy can only rise on a launch edge carrying frame sync (R9)
    assert_busy_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(tick && fsync_i));

endmodule

// File: tb/tb_dual_phase_ser_tx.sv
`timescale 1ns/1ps
module tb_dual_phase_ser_tx;

    localparam int WORD_W = 32;
    localparam int CNT_W  = 6;
    localparam int DLY_W  = 2;
    localparam int MAXB   = 4400;

    // {launch_fall, ph2_en, dly[1:0], p1w[2:0], p1cnt[5:0], p2w[2:0], p2cnt[5:0]}
    localparam int NVEC = 7;
    localparam logic [21:0] VEC [0:NVEC-1] = '{
        {1'b0, 1'b0, 2'd0, 3'd0, 6'd0,  3'd0, 6'd0},
        {1'b0, 1'b0, 2'd1, 3'd7, 6'd1,  3'd0, 6'd0},
        {1'b1, 1'b1, 2'd1, 3'd4, 6'd0,  3'd5, 6'd11},
        {1'b1, 1'b0, 2'd3, 3'd1, 6'd2,  3'd0, 6'd0},
        {1'b0, 1'b1, 2'd2, 3'd2, 6'd1,  3'd3, 6'd0},
        {1'b0, 1'b1, 2'd0, 3'd6, 6'd0,  3'd0, 6'd2},
        {1'b1, 1'b0, 2'd2, 3'd4, 6'd3,  3'd7, 6'd9}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bclk = 1'b0, fsync = 1'b0, launch_fall = 1'b0, ph2_en = 1'b0;
    logic [CNT_W-1:0] ph1_cnt = '0, ph2_cnt = '0;
    logic [2:0] ph1_w = '0, ph2_w = '0;
    logic [DLY_W-1:0] dly = '0;
    logic [WORD_W-1:0] in_data;
    logic in_valid, in_ready, sdata, busy, underrun, fs_err;

    int checks = 0, fails = 0;
    int widx = 0, wavail = 0, nready = 0, nunder = 0, nfserr = 0;
    logic got_bit [0:MAXB-1];
    logic got_busy [0:MAXB-1];
    logic exp_s [0:MAXB-1];
    int exp_len, exp_elems;

    always #4 clk = ~clk;

    function automatic logic [WORD_W-1:0] wordgen(input int i);
        return (32'h9E37_79B9 * (i + 1)) ^ 32'h5A5A_0F0F;
    endfunction

    function automatic int wbits(input logic [2:0] c);
        int t [0:7] = '{8, 10, 12, 14, 16, 20, 24, 32};
        return t[c];
    endfunction

    assign in_valid = widx < wavail;
    assign in_data  = wordgen(widx);

    always @(posedge clk) begin
        if (rst_n) begin
            if (in_valid && in_ready) begin widx <= widx + 1; nready <= nready + 1; end
            if (underrun) nunder <= nunder + 1;
            if (fs_err)   nfserr <= nfserr + 1;
        end
    end

    dual_phase_ser_tx #(.WORD_W(WORD_W), .CNT_W(CNT_W), .DLY_W(DLY_W)) dut (
        .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .fsync_i(fsync),
        .launch_fall_i(launch_fall), .ph2_en_i(ph2_en),
        .ph1_cnt_i(ph1_cnt), .ph1_wcode_i(ph1_w),
        .ph2_cnt_i(ph2_cnt), .ph2_wcode_i(ph2_w), .dly_i(dly),
        .in_data_i(in_data), .in_valid_i(in_valid), .in_ready_o(in_ready),
        .sdata_o(sdata), .busy_o(busy), .underrun_o(underrun), .fs_err_o(fs_err)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One launch edge, then the opposite edge; sample between them.
    task automatic do_tick(input logic fs, input int k);
        @(negedge clk); bclk = ~launch_fall; fsync = fs;
        @(negedge clk); fsync = 1'b0;
        @(negedge clk); got_bit[k] = sdata; got_busy[k] = busy;
        @(negedge clk); bclk = launch_fall;
        @(negedge clk);
    endtask

    task automatic apply_vec(input logic [21:0] v);
        @(negedge clk);
        launch_fall = v[21];
        bclk        = v[21];
        ph2_en      = v[20];
        dly         = v[19:18];
        ph1_w       = v[17:15];
        ph1_cnt     = v[14:9];
        ph2_w       = v[8:6];
        ph2_cnt     = v[5:0];
        repeat (2) @(negedge clk);
    endtask

    // Expected stream from the configuration, with the first 'avail' words present.
    task automatic build_exp(input int avail);
        int n1, n2, e;
        logic [WORD_W-1:0] w;
        n1 = int'(ph1_cnt) + 1;
        n2 = ph2_en ? int'(ph2_cnt) + 1 : 0;
        exp_len = 0; e = 0;
        for (int i = 0; i < n1 + n2; i++) begin
            int nb;
            nb = (i < n1) ? wbits(ph1_w) : wbits(ph2_w);
            w  = (e < avail) ? wordgen(e) : '0;
            for (int j = nb - 1; j >= 0; j--) begin
                exp_s[exp_len] = w[j];
                exp_len++;
            end
            e++;
        end
        exp_elems = n1 + n2;
    endtask

    task automatic run_frame(input string req, input int avail, input int fs_extra);
        int nt, bad_bit, bad_busy, d, first_bad;
        logic eb;
        widx = 0; wavail = avail; nready = 0; nunder = 0; nfserr = 0;
        build_exp(avail);
        d  = int'(dly);
        nt = d + exp_len + 2;
        for (int k = 0; k < nt; k++) do_tick(k == 0 || k == fs_extra, k);
        bad_bit = 0; bad_busy = 0; first_bad = -1;
        for (int k = 0; k < nt; k++) begin
            eb = (k >= d && k < d + exp_len) ? exp_s[k - d] : 1'b0;
            if (got_bit[k] !== eb) begin
                bad_bit++;
                if (first_bad < 0) first_bad = k;
            end
            if (got_busy[k] !== (k < d + exp_len)) bad_busy++;
        end
        check(req, "serial bit errors (R1 R2 R3 R4 R5 R6)", bad_bit, 0);
        if (bad_bit != 0) $display("  first bad bit at launch edge %0d", first_bad);
        check("R9", "busy window errors", bad_busy, 0);
        check("R11", "words taken", nready, (avail < exp_elems) ? avail : exp_elems);
    endtask

    initial begin
        #(8ns * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R10: reset state
        check("R10", "sdata", int'(sdata), 0);
        check("R10", "busy", int'(busy), 0);
        check("R10", "in_ready", int'(in_ready), 0);
        check("R10", "underrun", int'(underrun), 0);
        check("R10", "fs_err", int'(fs_err), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Table of configurations: widths R1, counts R2, phases R3, delays R4, edges R5
        for (int v = 0; v < NVEC; v++) begin
            apply_vec(VEC[v]);
            run_frame("R3", 64, -1);
            check("R7", "no underrun with words present", nunder, 0);
        end

        // R7: starve after first word of a three-element frame
        apply_vec(VEC[3]);
        run_frame("R7", 1, -1);
        check("R7", "underrun pulses", nunder, 2);

        // R8: extra frame sync in the middle of a frame is ignored
        apply_vec(VEC[1]);
        run_frame("R8", 64, 10);
        check("R8", "sync error pulses", nfserr, 1);

        // R8: sync during the lead-in delay is also ignored
        apply_vec(VEC[4]);
        run_frame("R8", 64, 1);
        check("R8", "sync error pulses in delay", nfserr, 1);

        // R9: after the frame the line stays idle
        check("R9", "busy after frame", int'(busy), 0);
        check("R9", "sdata after frame", int'(sdata), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule